// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

The block is a memory-mapped general-purpose I/O controller. Its pins are grouped into banks of 32; the last bank may be partial. Each bank has an output latch, a direction register, rising and falling edge enables, a sticky edge status register and an edge reporting mask. Software reads a level word for each bank. The output latch is changed only through two write-only strobe registers: one drives pins high and the other drives them low. Edge status bits are cleared by writing one to them.

Pin inputs pass through a two-flop synchroniser. An edge is a difference between the synchronised value and its value one cycle earlier. A captured edge stays in the status register until software clears it. An edge in the same cycle as a clear keeps the bit set. One registered interrupt output is high while any bank has a status bit that is also set in that bank's mask.

The register bus is a single-cycle slave. A request with write enable writes in the cycle it is presented. A read request returns its data on `busRdata` in the following cycle.

Top module: `pinbank_gpio`

## Requirements
- R1: After reset every register reads zero, `pinOut`, `pinOe` and `irqOut` are all zero.
- R2: Byte offsets of the register types are: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, edge status 0x48, mask 0x9C. Banks 0 to 2 sit at offset +4*bank from the type offset. Banks 3 to 5 sit at 0x100 + type offset + 4*(bank-3). Offsets that match no register, with bit 9 set, or naming an absent bank, read zero and ignore writes.
- R3: A write to the set register forces to 1 each latch bit whose written bit is 1. A write to the clear register forces to 0 each latch bit whose written bit is 1. Zero bits leave the latch alone. Both registers read zero.
- R4: Direction bit 1 makes the pin an output (`pinOe` bit high), and 0 makes it an input. `pinOut` always shows the latch.
- R5: The level word shows the latch for output pins and the synchronised input for input pins. The synchroniser has two flops, so the level word trails an input change by two clock edges.
- R6: A 0-to-1 input transition sets the pin's status bit when its rising enable is 1, and does nothing when it is 0.
- R7: A 1-to-0 input transition sets the status bit when its falling enable is 1. With both enables set, either transition sets it.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it set.
- R9: When an edge is detected in the same cycle a clear is written to the same status bit, the bit stays set.
- R10: `irqOut` is high one cycle after any status bit with its mask bit set becomes pending, and low one cycle after no such bit remains. Status bits with mask 0 never raise it.
- R11: In a partial last bank the unimplemented bits read zero and cannot be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| busReq | input | 1 | Bus request valid |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 10 | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after the request |
| pinIn | input | NUM_PINS | Pin input values |
| pinOut | output | NUM_PINS | Output latch |
| pinOe | output | NUM_PINS | Output drive enable |
| irqOut | output | 1 | Combined interrupt |

## Verification
The assertions take the bus to be a single-cycle protocol with known address and strobes whenever reset is released. They also take pin inputs to be held at zero during reset, so no transition appears when reset is released. The stimulus issues requests only at falling clock edges and holds each one for exactly one cycle. Each pin level is held for several cycles so every transition survives the two synchronising flops. The clear-versus-edge race is set up by timing a pin change two edges before the clear write.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 10;
  localparam int BANK_IDX_W = 3;
  localparam int NUM_TYPES = 8;
  localparam int TYPE_SPAN = 12;

  typedef enum logic [3:0] {
    RS_NONE, RS_LEVEL, RS_DIR, RS_SET, RS_CLR, RS_RISE, RS_FALL, RS_STAT, RS_MASK
  } regsel_e;

  // type offsets, in the same order as the regsel_e values after RS_NONE
  localparam logic [7:0] TYPE_BASE [NUM_TYPES] =
    '{8'h00, 8'h0C, 8'h18, 8'h24, 8'h30, 8'h3C, 8'h48, 8'h9C};

  typedef struct packed {
    logic wrDir;
    logic wrSet;
    logic wrClr;
    logic wrRise;
    logic wrFall;
    logic wrStat;
    logic wrMask;
    logic rdEn;
    regsel_e rsel;
    logic [BANK_IDX_W-1:0] bank;
  } bus_strobe_s;
endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
  import pinbank_pkg::*;
#(
  parameter int NUM_BANKS = 6
) (
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output bus_strobe_s       strb
);
  logic [7:0] low;
  logic       hit;
  regsel_e    sel;
  logic [1:0] slot;
  logic [3:0] bankWide;
  logic       valid;
  logic       wrOk;

  always_comb begin
    low  = busAddr[7:0];
    hit  = 1'b0;
    sel  = RS_NONE;
    slot = '0;
    for (int t = 0; t < NUM_TYPES; t++) begin
      if (low >= TYPE_BASE[t] && (low - TYPE_BASE[t]) < 8'(TYPE_SPAN) && low[1:0] == 2'b00) begin
        hit  = 1'b1;
        sel  = regsel_e'(4'(t + 1));
        slot = 2'((low - TYPE_BASE[t]) >> 2);
      end
    end
    bankWide = busAddr[8] ? 4'(slot) + 4'd3 : 4'(slot);
    valid    = hit && !busAddr[9] && (int'(bankWide) < NUM_BANKS);
    wrOk     = valid && busReq && busWe;

    strb.wrDir  = wrOk && sel == RS_DIR;
    strb.wrSet  = wrOk && sel == RS_SET;
    strb.wrClr  = wrOk && sel == RS_CLR;
    strb.wrRise = wrOk && sel == RS_RISE;
    strb.wrFall = wrOk && sel == RS_FALL;
    strb.wrStat = wrOk && sel == RS_STAT;
    strb.wrMask = wrOk && sel == RS_MASK;
    strb.rdEn   = busReq && !busWe;
    strb.rsel   = valid ? sel : RS_NONE;
    strb.bank   = bankWide[BANK_IDX_W-1:0];
  end
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS  = 176,
  parameter int NUM_BANKS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  bus_strobe_s         strb,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [WORD_W-1:0]   rdata,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqOut,
  output logic [NUM_PINS-1:0] statusVec,
  output logic [NUM_PINS-1:0] maskVec
);
  localparam int TOTAL_W = NUM_BANKS * WORD_W;
  localparam logic [TOTAL_W-1:0] VALID = {TOTAL_W{1'b1}} >> (TOTAL_W - NUM_PINS);

  logic [TOTAL_W-1:0] padIn, sync1, sync2, prevIn;
  logic [TOTAL_W-1:0] dirR, outR, riseR, fallR, statR, maskR;
  logic [TOTAL_W-1:0] selMask, wrBits, edgeHit, levelVec, srcVec;
  logic [WORD_W-1:0]  word, rdR;
  logic               irqR;

  assign padIn = TOTAL_W'(pinIn);

  // place the written word over the addressed bank
  always_comb begin
    selMask = '0;
    wrBits  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strb.bank == BANK_IDX_W'(b)) begin
        selMask[b*WORD_W +: WORD_W] = '1;
        wrBits[b*WORD_W +: WORD_W]  = wdata;
      end
    end
  end

  assign edgeHit  = ((sync2 & ~prevIn & riseR) | (~sync2 & prevIn & fallR)) & VALID;
  assign levelVec = ((dirR & outR) | (~dirR & sync2)) & VALID;

  always_comb begin
    case (strb.rsel)
      RS_LEVEL: srcVec = levelVec;
      RS_DIR:   srcVec = dirR;
      RS_RISE:  srcVec = riseR;
      RS_FALL:  srcVec = fallR;
      RS_STAT:  srcVec = statR;
      RS_MASK:  srcVec = maskR;
      default:  srcVec = '0;
    endcase
    word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strb.bank == BANK_IDX_W'(b)) word = srcVec[b*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      prevIn <= '0;
      dirR   <= '0;
      outR   <= '0;
      riseR  <= '0;
      fallR  <= '0;
      statR  <= '0;
      maskR  <= '0;
      irqR   <= 1'b0;
      rdR    <= '0;
    end else begin
      sync1  <= padIn;
      sync2  <= sync1;
      prevIn <= sync2;
      if (strb.wrDir)  dirR  <= (dirR  & ~selMask) | (wrBits & VALID);
      if (strb.wrRise) riseR <= (riseR & ~selMask) | (wrBits & VALID);
      if (strb.wrFall) fallR <= (fallR & ~selMask) | (wrBits & VALID);
      if (strb.wrMask) maskR <= (maskR & ~selMask) | (wrBits & VALID);
      if (strb.wrSet)      outR <= outR | (wrBits & VALID);
      else if (strb.wrClr) outR <= outR & ~wrBits;
      // a new edge overrides a simultaneous clear
      statR <= edgeHit | (statR & ~(strb.wrStat ? wrBits : '0));
      irqR  <= |(statR & maskR);
      rdR   <= strb.rdEn ? word : '0;
    end
  end

  assign rdata     = rdR;
  assign pinOut    = outR[NUM_PINS-1:0];
  assign pinOe     = dirR[NUM_PINS-1:0];
  assign irqOut    = irqR;
  assign statusVec = statR[NUM_PINS-1:0];
  assign maskVec   = maskR[NUM_PINS-1:0];
endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS = 176
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busReq,
  input  logic                busWe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [WORD_W-1:0]   busWdata,
  output logic [WORD_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqOut
);
  localparam int NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;

  bus_strobe_s         strb;
  logic [NUM_PINS-1:0] statusVec;
  logic [NUM_PINS-1:0] maskVec;

  pinbank_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
    .busReq (busReq),
    .busWe  (busWe),
    .busAddr(busAddr),
    .strb   (strb)
  );

  pinbank_regs #(.NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .wdata    (busWdata),
    .pinIn    (pinIn),
    .rdata    (busRdata),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .irqOut   (irqOut),
    .statusVec(statusVec),
    .maskVec  (maskVec)
  );
endmodule

// File: rtl/pinbank_gpio_chk.sv
module pinbank_gpio_chk #(
  parameter int NUM_PINS = 176
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busReq,
  input logic                busWe,
  input logic [9:0]          busAddr,
  input logic [31:0]         busRdata,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] pinOe,
  input logic                irqOut,
  input logic [NUM_PINS-1:0] statusVec,
  input logic [NUM_PINS-1:0] maskVec
);
  logic [7:0] low;
  logic inMap, wrReq, rdReq, setHit, clrHit, dirHit, statHit, woRead;

  assign low     = busAddr[7:0];
  assign inMap   = !busAddr[9];
  assign wrReq   = busReq && busWe && inMap;
  assign rdReq   = busReq && !busWe && inMap;
  assign setHit  = wrReq && low >= 8'h18 && low < 8'h24;
  assign clrHit  = wrReq && low >= 8'h24 && low < 8'h30;
  assign dirHit  = wrReq && low >= 8'h0C && low < 8'h18;
  assign statHit = wrReq && low >= 8'h48 && low < 8'h54;
  assign woRead  = rdReq && low >= 8'h18 && low < 8'h30;

  assert_irq_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irqOut == $past(|(statusVec & maskVec))));

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(statHit) |-> ((~statusVec & $past(statusVec)) == '0));

  assert_latch_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(setHit) |-> ((pinOut & ~$past(pinOut)) == '0));

  assert_latch_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clrHit) |-> ((~pinOut & $past(pinOut)) == '0));

  assert_strobe_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    woRead |=> (busRdata == '0));

  assert_oe_needs_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dirHit) |-> $stable(pinOe));
endmodule

bind pinbank_gpio pinbank_gpio_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busReq   (busReq),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .pinOut   (pinOut),
  .pinOe    (pinOe),
  .irqOut   (irqOut),
  .statusVec(statusVec),
  .maskVec  (maskVec)
);

// File: tb/pinbank_gpio_tb.sv
module pinbank_gpio_tb;
  localparam int NP = 176;
  localparam logic [7:0] O_LEVEL = 8'h00, O_DIR = 8'h0C, O_SET = 8'h18, O_CLR = 8'h24,
                         O_RISE = 8'h30, O_FALL = 8'h3C, O_STAT = 8'h48, O_MASK = 8'h9C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          busReq = 1'b0;
  logic          busWe = 1'b0;
  logic [9:0]    busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] pinOut;
  logic [NP-1:0] pinOe;
  logic          irqOut;
  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  pinbank_gpio #(.NUM_PINS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irqOut(irqOut)
  );

  function automatic logic [9:0] ra(logic [7:0] off, int bank);
    return 10'((bank >= 3 ? 256 : 0) + int'(off) + 4 * (bank % 3));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic busWrite(logic [9:0] a, logic [31:0] d);
    busReq = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busReq = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(logic [9:0] a, output logic [31:0] d);
    busReq = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk);
    busReq = 1'b0;
    d = busRdata;
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic test_reset();
    logic [31:0] v;
    check("R1 irq", {31'b0, irqOut}, 32'h0);
    check("R1 oe", {31'b0, |pinOe}, 32'h0);
    check("R1 out", {31'b0, |pinOut}, 32'h0);
    busRead(ra(O_DIR, 0), v);  check("R1 dir0", v, 32'h0);
    busRead(ra(O_MASK, 5), v); check("R1 mask5", v, 32'h0);
    busRead(ra(O_STAT, 3), v); check("R1 stat3", v, 32'h0);
    busRead(ra(O_LEVEL, 1), v); check("R1 level1", v, 32'h0);
  endtask

  task automatic test_set_clear();
    logic [31:0] v;
    busWrite(ra(O_DIR, 1), 32'hFFFF_FFFF);
    busWrite(ra(O_SET, 1), 32'h0000_00F0);
    check("R3 set", pinOut[63:32], 32'h0000_00F0);
    busWrite(ra(O_SET, 1), 32'h0000_0003);
    check("R3 set keeps", pinOut[63:32], 32'h0000_00F3);
    busWrite(ra(O_CLR, 1), 32'h0000_0010);
    check("R3 clear", pinOut[63:32], 32'h0000_00E3);
    busRead(ra(O_SET, 1), v); check("R3 set reads zero", v, 32'h0);
    busRead(ra(O_CLR, 1), v); check("R3 clear reads zero", v, 32'h0);
    check("R4 oe bank1", pinOe[63:32], 32'hFFFF_FFFF);
    check("R4 oe bank0", pinOe[31:0], 32'h0);
    busRead(ra(O_LEVEL, 1), v); check("R5 output level", v, 32'h0000_00E3);
  endtask

  task automatic test_level();
    logic [31:0] v;
    pinIn[31:0] = 32'hA5A5_1234;
    waitCycles(4);
    busRead(ra(O_LEVEL, 0), v); check("R5 input level", v, 32'hA5A5_1234);
    busWrite(ra(O_DIR, 0), 32'hFFFF_0000);
    busWrite(ra(O_SET, 0), 32'hFF00_0000);
    busRead(ra(O_LEVEL, 0), v); check("R5 mixed level", v, 32'hFF00_1234);
    pinIn[31:0] = 32'h0;
    waitCycles(1);
    busRead(ra(O_LEVEL, 0), v); check("R5 sync lag", v, 32'hFF00_1234);
    waitCycles(2);
    busRead(ra(O_LEVEL, 0), v); check("R5 after sync", v, 32'hFF00_0000);
  endtask

  task automatic test_map();
    logic [31:0] v;
    for (int b = 0; b < 6; b++) busWrite(ra(O_MASK, b), 32'h0101_0101 * (b + 1));
    for (int b = 0; b < 5; b++) begin
      busRead(ra(O_MASK, b), v); check($sformatf("R2 mask bank%0d", b), v, 32'h0101_0101 * (b + 1));
    end
    busRead(ra(O_MASK, 5), v); check("R11 mask partial bank", v, 32'h0000_0606);
    busRead(10'h060, v); check("R2 unmapped read", v, 32'h0);
    busWrite(10'h20C, 32'hFFFF_FFFF);
    busRead(ra(O_DIR, 0), v); check("R2 region 2 write ignored", v, 32'hFFFF_0000);
    busRead(10'h20C, v); check("R2 region 2 read", v, 32'h0);
    busWrite(ra(O_DIR, 5), 32'hFFFF_FFFF);
    busRead(ra(O_DIR, 5), v); check("R11 dir partial bank", v, 32'h0000_FFFF);
    check("R11 oe partial bank", {16'h0, pinOe[175:160]}, 32'h0000_FFFF);
  endtask

  task automatic test_rising();
    logic [31:0] v;
    busWrite(ra(O_RISE, 2), 32'h1);
    pinIn[64] = 1'b1; waitCycles(4);
    busRead(ra(O_STAT, 2), v); check("R6 rise captured", v, 32'h1);
    busWrite(ra(O_STAT, 2), 32'h1);
    pinIn[64] = 1'b0; waitCycles(4);
    busRead(ra(O_STAT, 2), v); check("R6 fall ignored without enable", v, 32'h0);
    pinIn[65] = 1'b1; waitCycles(4);
    busRead(ra(O_STAT, 2), v); check("R6 rise ignored without enable", v, 32'h0);
    pinIn[65] = 1'b0; waitCycles(4);
  endtask

  task automatic test_falling_both();
    logic [31:0] v;
    busWrite(ra(O_RISE, 2), 32'h5);
    busWrite(ra(O_FALL, 2), 32'h6);
    pinIn[65] = 1'b1; waitCycles(4);
    busRead(ra(O_STAT, 2), v); check("R7 rise not enabled", v, 32'h0);
    pinIn[65] = 1'b0; waitCycles(4);
    busRead(ra(O_STAT, 2), v); check("R7 fall captured", v, 32'h2);
    busWrite(ra(O_STAT, 2), 32'h2);
    pinIn[66] = 1'b1; waitCycles(4);
    busRead(ra(O_STAT, 2), v); check("R7 both: rise", v, 32'h4);
    busWrite(ra(O_STAT, 2), 32'h4);
    pinIn[66] = 1'b0; waitCycles(4);
    busRead(ra(O_STAT, 2), v); check("R7 both: fall", v, 32'h4);
    busWrite(ra(O_STAT, 2), 32'h4);
  endtask

  task automatic test_w1c();
    logic [31:0] v;
    pinIn[64] = 1'b1; waitCycles(4);
    busWrite(ra(O_STAT, 2), 32'h0);
    busRead(ra(O_STAT, 2), v); check("R8 zero write keeps", v, 32'h1);
    busWrite(ra(O_STAT, 2), 32'hFFFF_FFFA);
    busRead(ra(O_STAT, 2), v); check("R8 other bits keep", v, 32'h1);
    busWrite(ra(O_STAT, 2), 32'h1);
    busRead(ra(O_STAT, 2), v); check("R8 one clears", v, 32'h0);
  endtask

  task automatic test_race();
    logic [31:0] v;
    pinIn[66] = 1'b1; waitCycles(4);
    busRead(ra(O_STAT, 2), v); check("R9 setup", v, 32'h4);
    pinIn[66] = 1'b0;
    waitCycles(2);
    busWrite(ra(O_STAT, 2), 32'h4);
    busRead(ra(O_STAT, 2), v); check("R9 edge beats clear", v, 32'h4);
    busWrite(ra(O_STAT, 2), 32'h4);
    busRead(ra(O_STAT, 2), v); check("R9 later clear", v, 32'h0);
  endtask

  task automatic test_irq();
    logic [31:0] v;
    busWrite(ra(O_MASK, 2), 32'h0);
    pinIn[64] = 1'b0; waitCycles(4);
    pinIn[64] = 1'b1; waitCycles(4);
    busRead(ra(O_STAT, 2), v); check("R10 pending", v, 32'h1);
    check("R10 masked off", {31'b0, irqOut}, 32'h0);
    busWrite(ra(O_MASK, 2), 32'h1);
    check("R10 one-cycle delay", {31'b0, irqOut}, 32'h0);
    waitCycles(1);
    check("R10 raised", {31'b0, irqOut}, 32'h1);
    busWrite(ra(O_STAT, 2), 32'h1);
    waitCycles(1);
    check("R10 dropped", {31'b0, irqOut}, 32'h0);
  endtask

  initial begin
    waitCycles(3);
    rst_n = 1'b1;
    waitCycles(1);
    test_reset();
    test_set_clear();
    test_level();
    test_map();
    test_rising();
    test_falling_both();
    test_w1c();
    test_race();
    test_irq();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500us;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule